// File: doc/BRIEF.md
# Slow-Tick Real-Time Counter with Dual Compare

This block is a free-running up-counter for a low-frequency timekeeping domain. It advances by one only on cycles where a slow tick enable is high, so it can sit on a fast fabric clock while counting a slow time base. Two compare values, a run bit, a debug-run bit and a wrap-at-compare-0 bit arrive already synchronized into the block's domain as plain inputs. The block outputs the live count, three sticky event flags and one interrupt request.

The counter is 24 bits wide by default. Normally it rolls over after its all-ones value. When the wrap-select input is high, it instead returns to zero on the advancing tick after it has reached the compare-0 value, which gives a programmable period. Dropping the run input holds the count at zero, so turning run off and on again restarts the count from zero.

A small register port gives software three things: read access to the flags, a read/write interrupt-enable mask, and a write-one-to-clear register for the flags.

Top module: `slowcnt_top`

## Requirements
- R1: After reset the count, all flags, the interrupt-enable mask and irq_o are zero.
- R2: While cfg_run is high, count_o rises by one on each clock edge where tick_en is high and the debug halt does not apply. It keeps its value on every other edge.
- R3: With cfg_top_sel low, an advancing tick at the all-ones count (2^CNT_W-1) sets the count to zero and sets the overflow flag, flags_o bit 0.
- R4: With cfg_top_sel high, an advancing tick at a count equal to cmp0_val sets the count to zero and sets flags_o bit 0. A count above cmp0_val continues up to all-ones and wraps there.
- R5: On an advancing tick where the count before the tick equals cmp0_val, flags_o bit 1 sets. Where it equals cmp1_val, flags_o bit 2 sets.
- R6: While cfg_run is low the count is forced to zero and no flag sets. The first advancing tick after run returns gives a count of one.
- R7: With dbg_halt high and cfg_dbg_run low the count is frozen. With cfg_dbg_run high, dbg_halt has no effect.
- R8: A write to address 2 clears every flag whose wdata bit is 1 and leaves the others unchanged. If a flag's event occurs in the same cycle as its clear, the flag ends up set.
- R9: Address 1 holds the interrupt-enable mask, which uses the same bit order as the flags. irq_o is high exactly when some flag and its enable bit are both 1.
- R10: reg_rdata returns the flags at address 0, the enable mask at address 1, and zero at addresses 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Slow time-base enable; counting happens only on these cycles |
| dbg_halt | input | 1 | Debugger halt indication |
| cfg_run | input | 1 | Counter run bit (synchronized) |
| cfg_dbg_run | input | 1 | Keep counting while halted (synchronized) |
| cfg_top_sel | input | 1 | Wrap at compare 0 instead of all-ones (synchronized) |
| cmp0_val | input | CNT_W | Compare value 0, also the wrap value when selected |
| cmp1_val | input | CNT_W | Compare value 1 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 flags, 1 enable mask, 2 clear |
| reg_wdata | input | 3 | Register write data |
| reg_rdata | output | 3 | Register read data |
| count_o | output | CNT_W | Current count |
| flags_o | output | 3 | Sticky flags: bit 0 wrap, bit 1 compare 0, bit 2 compare 1 |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of functions can land in the same cycle. In wrap-at-compare-0 mode, the wrap and the compare-0 match fire on the same tick. A flag-clear write can also coincide with a new event on that flag. The bench provokes the first by running the counter into a small compare-0 value, and the second by timing an all-ones clear write to the exact cycle in which the count sits on cmp1_val. Afterwards it expects the wrap and compare-0 flags to rise together, and the compare-1 flag to survive its clear. A per-cycle behavioural model also judges thousands of random cycles in which clears, enable writes, halts and ticks overlap freely.

// File: rtl/slowcnt_pkg.sv
package slowcnt_pkg;

   localparam int NUM_CMP   = 2;
   localparam int NUM_FLAGS = NUM_CMP + 1;
   localparam int FLAG_WRAP = 0;
   localparam int ADDR_W    = 2;

   typedef enum logic [ADDR_W-1:0] {
      ADR_FLAGS = 2'd0,
      ADR_IEN   = 2'd1,
      ADR_CLR   = 2'd2,
      ADR_SPARE = 2'd3
   } slowcnt_addr_e;

endpackage

// File: rtl/slowcnt_core.sv
module slowcnt_core #(
   parameter int CNT_W   = 24,
   parameter bit HAS_TOP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             adv_i,
   input  logic             top_sel_i,
   input  logic [CNT_W-1:0] top_val_i,
   output logic [CNT_W-1:0] count_o,
   output logic             wrap_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic             at_max;
   logic             at_top;

   assign at_max = (cnt_q == CNT_MAX);

   generate
      if (HAS_TOP) begin : g_top
         assign at_top = top_sel_i && (cnt_q == top_val_i);
      end else begin : g_no_top
         logic unused_top;
         assign unused_top = top_sel_i ^ (^top_val_i);
         assign at_top     = 1'b0;
      end
   endgenerate

   assign wrap_o = adv_i && (at_max || at_top);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i) begin
         cnt_q <= '0;
      end else if (wrap_o) begin
         cnt_q <= '0;
      end else if (adv_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign count_o = cnt_q;

endmodule

// File: rtl/slowcnt_match.sv
module slowcnt_match #(
   parameter int CNT_W = 24,
   parameter int NCMP  = 2
) (
   input  logic             adv_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic [CNT_W-1:0] cmp_i [NCMP],
   output logic [NCMP-1:0]  hit_o
);

   generate
      for (genvar k = 0; k < NCMP; k++) begin : g_cmp
         assign hit_o[k] = adv_i && (count_i == cmp_i[k]);
      end
   endgenerate

endmodule

// File: rtl/slowcnt_flags.sv
module slowcnt_flags
   import slowcnt_pkg::*;
#(
   parameter int NFLAG = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NFLAG-1:0]  set_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [NFLAG-1:0]  wdata_i,
   output logic [NFLAG-1:0]  flags_o,
   output logic [NFLAG-1:0]  ien_o,
   output logic              irq_o,
   output logic [NFLAG-1:0]  rdata_o
);

   logic [NFLAG-1:0] flg_q;
   logic [NFLAG-1:0] ien_q;
   logic [NFLAG-1:0] clr_mask;
   slowcnt_addr_e    adr;

   assign adr      = slowcnt_addr_e'(addr_i);
   assign clr_mask = (wr_i && adr == ADR_CLR) ? wdata_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flg_q <= '0;
      end else begin
         flg_q <= (flg_q & ~clr_mask) | set_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q <= '0;
      end else if (wr_i && adr == ADR_IEN) begin
         ien_q <= wdata_i;
      end
   end

   always_comb begin
      unique case (adr)
         ADR_FLAGS: rdata_o = flg_q;
         ADR_IEN:   rdata_o = ien_q;
         default:   rdata_o = '0;
      endcase
   end

   assign flags_o = flg_q;
   assign ien_o   = ien_q;
   assign irq_o   = |(flg_q & ien_q);

endmodule

// File: rtl/slowcnt_top.sv
module slowcnt_top
   import slowcnt_pkg::*;
#(
   parameter int CNT_W   = 24,
   parameter bit HAS_TOP = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_en,
   input  logic                 dbg_halt,
   input  logic                 cfg_run,
   input  logic                 cfg_dbg_run,
   input  logic                 cfg_top_sel,
   input  logic [CNT_W-1:0]     cmp0_val,
   input  logic [CNT_W-1:0]     cmp1_val,
   input  logic                 reg_wr,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [NUM_FLAGS-1:0] reg_wdata,
   output logic [NUM_FLAGS-1:0] reg_rdata,
   output logic [CNT_W-1:0]     count_o,
   output logic [NUM_FLAGS-1:0] flags_o,
   output logic                 irq_o
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("slowcnt_top: CNT_W must lie in 2..32");
      end
      if (NUM_CMP < 1) begin : g_bad_cmp
         $error("slowcnt_top: at least one compare channel required");
      end
   endgenerate

   logic                 adv;
   logic                 wrap;
   logic [NUM_CMP-1:0]   hit;
   logic [CNT_W-1:0]     cmp_arr [NUM_CMP];
   logic [NUM_FLAGS-1:0] ev;
   logic [NUM_FLAGS-1:0] ien;

   assign adv        = cfg_run && tick_en && (!dbg_halt || cfg_dbg_run);
   assign cmp_arr[0] = cmp0_val;
   assign cmp_arr[1] = cmp1_val;
   assign ev         = {hit, wrap};

   slowcnt_core #(.CNT_W(CNT_W), .HAS_TOP(HAS_TOP)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (cfg_run),
      .adv_i     (adv),
      .top_sel_i (cfg_top_sel),
      .top_val_i (cmp0_val),
      .count_o   (count_o),
      .wrap_o    (wrap)
   );

   slowcnt_match #(.CNT_W(CNT_W), .NCMP(NUM_CMP)) u_match (
      .adv_i   (adv),
      .count_i (count_o),
      .cmp_i   (cmp_arr),
      .hit_o   (hit)
   );

   slowcnt_flags #(.NFLAG(NUM_FLAGS)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (ev),
      .wr_i    (reg_wr),
      .addr_i  (reg_addr),
      .wdata_i (reg_wdata),
      .flags_o (flags_o),
      .ien_o   (ien),
      .irq_o   (irq_o),
      .rdata_o (reg_rdata)
   );

endmodule

// File: rtl/slowcnt_chk.sv
module slowcnt_chk #(
   parameter int CNT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_en,
   input logic             dbg_halt,
   input logic             cfg_run,
   input logic             cfg_dbg_run,
   input logic             cfg_top_sel,
   input logic [CNT_W-1:0] cmp0_val,
   input logic [CNT_W-1:0] cmp1_val,
   input logic             reg_wr,
   input logic [1:0]       reg_addr,
   input logic [2:0]       reg_wdata,
   input logic [CNT_W-1:0] count_o,
   input logic [2:0]       flags_o
);

   localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

   logic go;
   logic at_end;
   assign go     = cfg_run && tick_en && (!dbg_halt || cfg_dbg_run);
   assign at_end = (count_o == ALL1) || (cfg_top_sel && count_o == cmp0_val);

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !at_end) |=> count_o == $past(count_o) + 1'b1);

   assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_run && !tick_en) |=> $stable(count_o));

   assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (go && count_o == ALL1) |=> (count_o == '0) && flags_o[0]);

   assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (go && cfg_top_sel && count_o == cmp0_val) |=> (count_o == '0) && flags_o[0]);

   assert_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (go && count_o == cmp1_val) |=> flags_o[2]);

   assert_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_run |=> count_o == '0);

   assert_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_run && dbg_halt && !cfg_dbg_run) |=> $stable(count_o));

   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd2 && !cfg_run) |=> (flags_o & $past(reg_wdata)) == 3'b000);

endmodule

bind slowcnt_top slowcnt_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_en     (tick_en),
   .dbg_halt    (dbg_halt),
   .cfg_run     (cfg_run),
   .cfg_dbg_run (cfg_dbg_run),
   .cfg_top_sel (cfg_top_sel),
   .cmp0_val    (cmp0_val),
   .cmp1_val    (cmp1_val),
   .reg_wr      (reg_wr),
   .reg_addr    (reg_addr),
   .reg_wdata   (reg_wdata),
   .count_o     (count_o),
   .flags_o     (flags_o)
);

// File: tb/sim_slowcnt_top.sv
`timescale 1ns/1ps
module sim_slowcnt_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0, dbg_halt = 1'b0;
   logic        cfg_run = 1'b0, cfg_dbg_run = 1'b0, cfg_top_sel = 1'b0;
   logic [23:0] cmp0 = '0, cmp1 = '0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [2:0]  reg_wdata = 3'd0;

   logic [2:0]  rd0, rd1, fl0, fl1;
   logic [23:0] cnt0;
   logic [7:0]  cnt1;
   logic        irq0, irq1;

   int nchk = 0, nerr = 0;
   bit done = 1'b0;
   string cur = "R2";

   always #2 clk = ~clk;

   slowcnt_top u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .dbg_halt(dbg_halt),
      .cfg_run(cfg_run), .cfg_dbg_run(cfg_dbg_run), .cfg_top_sel(cfg_top_sel),
      .cmp0_val(cmp0), .cmp1_val(cmp1), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(rd0), .count_o(cnt0), .flags_o(fl0), .irq_o(irq0));

   slowcnt_top #(.CNT_W(8)) u1 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .dbg_halt(dbg_halt),
      .cfg_run(cfg_run), .cfg_dbg_run(cfg_dbg_run), .cfg_top_sel(cfg_top_sel),
      .cmp0_val(cmp0[7:0]), .cmp1_val(cmp1[7:0]), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(rd1), .count_o(cnt1), .flags_o(fl1), .irq_o(irq1));

   // behavioural reference, index 0 = 24-bit instance, 1 = 8-bit instance
   longint unsigned m_cnt [2];
   int              m_flg [2];
   int              m_ien [2];
   int              wid   [2] = '{24, 8};

   initial begin
      for (int i = 0; i < 2; i++) begin m_cnt[i] = 0; m_flg[i] = 0; m_ien[i] = 0; end
   end

   always @(posedge clk) begin
      for (int i = 0; i < 2; i++) begin
         longint unsigned mx, c0, c1;
         int ev, clr;
         bit go;
         mx = (longint'(1) << wid[i]) - 1;
         c0 = cmp0 & mx;
         c1 = cmp1 & mx;
         if (!rst_n) begin
            m_cnt[i] = 0; m_flg[i] = 0; m_ien[i] = 0;
         end else begin
            go = cfg_run && tick_en && (!dbg_halt || cfg_dbg_run);
            ev = 0;
            if (go) begin
               if (m_cnt[i] == mx || (cfg_top_sel && m_cnt[i] == c0)) ev |= 1;
               if (m_cnt[i] == c0) ev |= 2;
               if (m_cnt[i] == c1) ev |= 4;
            end
            if (!cfg_run) m_cnt[i] = 0;
            else if (ev[0]) m_cnt[i] = 0;
            else if (go) m_cnt[i] = m_cnt[i] + 1;
            clr = (reg_wr && reg_addr == 2'd2) ? int'(reg_wdata) : 0;
            m_flg[i] = (m_flg[i] & ~clr) | ev;
            if (reg_wr && reg_addr == 2'd1) m_ien[i] = int'(reg_wdata);
         end
      end
   end

   task automatic chk(input string req, input longint act, input longint exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int m_rd(input int i);
      if (reg_addr == 2'd0) return m_flg[i];
      if (reg_addr == 2'd1) return m_ien[i];
      return 0;
   endfunction

   task automatic cyc();
      @(negedge clk);
      chk({cur, " count u0"}, cnt0, m_cnt[0]);
      chk({cur, " count u1"}, cnt1, m_cnt[1]);
      chk("R5 flags u0", fl0, m_flg[0]);
      chk("R5 flags u1", fl1, m_flg[1]);
      chk("R9 irq u0", irq0, (m_flg[0] & m_ien[0]) != 0);
      chk("R9 irq u1", irq1, (m_flg[1] & m_ien[1]) != 0);
      chk("R10 rdata u0", rd0, m_rd(0));
      chk("R10 rdata u1", rd1, m_rd(1));
   endtask

   task automatic wr(input logic [1:0] a, input logic [2:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      cyc();
      reg_wr = 1'b0;
   endtask

   initial begin
      #(4 * 150000);
      nerr++;
      $display("FAIL watchdog expired");
      if (!done) begin
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cur = "R1";
      cyc();
      chk("R1 reset count", cnt0, 0);
      chk("R1 reset flags", fl0, 0);
      chk("R1 reset irq", irq0, 0);
      reg_addr = 2'd1; cyc();
      chk("R1 reset ien", rd0, 0);

      // R4 and R5: wrap at compare 0 with simultaneous compare-0 match
      cur = "R4";
      cfg_top_sel = 1'b1; cmp0 = 24'd3; cmp1 = 24'd7; cfg_run = 1'b1; tick_en = 1'b1;
      reg_addr = 2'd0;
      for (int k = 0; k < 10 && cnt0 != 24'd3; k++) cyc();
      cyc();
      chk("R4 wrap to zero", cnt0, 0);
      chk("R4 wrap and R5 match flags", fl0, 3'b011);
      repeat (12) cyc();

      // R3: natural wrap of the 8-bit instance
      cur = "R3";
      cfg_top_sel = 1'b0;
      wr(2'd2, 3'b111);
      for (int k = 0; k < 300 && cnt1 != 8'hFF; k++) cyc();
      cyc();
      chk("R3 natural wrap u1 count", cnt1, 0);
      chk("R3 natural wrap u1 flag", fl1[0], 1);
      chk("R3 no wrap yet u0", fl0[0], 0);

      // R6: run off clears, run on restarts
      cur = "R6";
      cfg_run = 1'b0; cyc(); cyc();
      chk("R6 held at zero", cnt0, 0);
      cfg_run = 1'b1; cyc();
      chk("R6 restart", cnt0, 1);

      // R7: debug halt freeze and debug-run override
      cur = "R7";
      repeat (5) cyc();
      dbg_halt = 1'b1; cfg_dbg_run = 1'b0;
      begin
         logic [23:0] held;
         cyc(); held = cnt0;
         repeat (3) cyc();
         chk("R7 frozen in halt", cnt0, held);
         cfg_dbg_run = 1'b1; cyc();
         chk("R7 debug-run counts", cnt0, held + 1);
      end
      dbg_halt = 1'b0;

      // R8: clear coinciding with a compare-1 event; set wins
      cur = "R8";
      cmp0 = 24'hFFF000; cmp1 = cnt0 + 24'd4;
      for (int k = 0; k < 10 && cnt0 != cmp1; k++) cyc();
      wr(2'd2, 3'b111);
      chk("R8 set beats clear", fl0, 3'b100);
      wr(2'd2, 3'b000);
      chk("R8 zero bits keep flag", fl0, 3'b100);

      // R9 / R10: enable mask, interrupt and read map
      cur = "R9";
      wr(2'd1, 3'b100);
      reg_addr = 2'd1; cyc();
      chk("R9 ien readback", rd0, 3'b100);
      chk("R9 irq raised", irq0, 1);
      reg_addr = 2'd3; cyc();
      chk("R10 spare reads zero", rd0, 0);
      wr(2'd2, 3'b100);
      chk("R9 irq dropped", irq0, 0);

      // random overlap of every function, model-checked each cycle
      cur = "R2";
      cfg_top_sel = 1'b1; cmp0 = 24'd20; cmp1 = 24'd9;
      for (int k = 0; k < 6000; k++) begin
         tick_en = ($urandom % 3) != 0;
         dbg_halt = ($urandom % 5) == 0;
         cfg_dbg_run = $urandom % 2;
         if ($urandom % 150 == 0) cfg_run = ~cfg_run;
         if ($urandom % 300 == 0) cfg_top_sel = ~cfg_top_sel;
         if ($urandom % 100 == 0) cmp0 = 24'($urandom % 40);
         if ($urandom % 100 == 0) cmp1 = 24'($urandom % 40);
         reg_wr = ($urandom % 6) == 0;
         reg_addr = 2'($urandom);
         reg_wdata = 3'($urandom);
         cyc();
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule